// File: doc/BRIEF.md
# Prescaled 16-bit Timer Counter with Coherent Byte Reads

This block is a free-running 16-bit up-counter that sits behind an 8-bit register port. A small control register picks what makes the counter advance. It can be the bus clock divided by a power of two from 1 to 64, or rising edges on an external clock pin. All logic runs in the bus clock domain. The divider and the external input both produce single-cycle count enables.

Software reads the count one byte at a time. Reading the high byte freezes a copy of the low byte. The next low-byte read returns that copy, so the two bytes always belong to the same count value, even if a carry crosses from low to high between the two reads. The control register also holds a self-clearing bit that restarts the counter, the divider and the byte latch together.

Register addresses: 0 is the control register, 1 is the count high byte and 2 is the count low byte. Control bits [2:0] hold the source code. Bit 4 is the restart bit.

Top module: `prescaled_count16`

## Requirements
- R1: After reset, the source code is 000, the count is 0x0000, the low-byte latch is empty, and the counter advances once per bus clock.
- R2: A source code k from 0 to 6 (control bits [2:0]) makes the count advance once every 2^k bus clocks. A restart write aligns the first advance to bus clock number 2^k after the write.
- R3: Source code 111 makes the count advance once for each rising edge of the external clock pin, after a synchronizer. While the pin is static, the count holds.
- R4: A read of address 1 returns the live high byte and captures the low byte of that same cycle. The next read of address 2 returns the captured byte, so the two reads form one consistent 16-bit value across a low-to-high carry.
- R5: Further reads of address 1 while the capture is held return the live high byte and leave the captured low byte unchanged.
- R6: The captured low byte stays held for any length of time until address 2 is read. A read of address 2 releases it, and later reads of address 2 return the live low byte.
- R7: Writes to address 1 or 2 change neither the count nor the control register.
- R8: Writing 1 to control bit 4 clears the count to 0x0000, restarts the divider and releases the low-byte latch. The same write loads bits [2:0]. A read of address 0 returns the source code in bits [2:0] and 0 in every other bit, including bit 4.
- R9: The count wraps from 0xFFFF to 0x0000 and keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| bus_addr | input | 2 | Register address (0 control, 1 count high, 2 count low) |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access; read side effects take place at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| ext_clk | input | 1 | External count clock, asynchronous, below half the bus clock rate |

## Verification
Every divider code 0 to 6 is restarted and then sampled at two unrelated distances from the restart. Sampling at such distances separates a wrong tap, an off-by-one in alignment and a divider that was not restarted. The byte latch is tried with three patterns: a read pair that straddles the 0x01FF to 0x0200 carry, which a live low byte would corrupt; a second high read between the pair, which would overwrite a latch that does not hold; and a read pair with a 1000-cycle gap, followed by a lone low read that must show the live value again. A restart between the high and low reads, writes to the read-only addresses, a run past 0xFFFF and a burst of external edges followed by a quiet pin complete the set.

// File: rtl/pc_pkg.sv
package pc_pkg;
  localparam int SEL_W   = 3;
  localparam int DIV_W   = 6;
  localparam int CLR_BIT = 4;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_HI   = 2'd1;
  localparam logic [1:0] ADDR_LO   = 2'd2;
  localparam logic [SEL_W-1:0] SRC_EXT = '1;
endpackage

// File: rtl/pc_prescaler.sv
module pc_prescaler import pc_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int NTAP = 2**SEL_W;

  logic [DIV_W-1:0] div_q, div_d;
  logic [NTAP-1:0]  taps;

  genvar gi;
  generate
    for (gi = 0; gi < NTAP; gi++) begin : g_tap
      if (gi == 0) begin : g_full
        assign taps[gi] = 1'b1;
      end else if (gi <= DIV_W) begin : g_div
        assign taps[gi] = &div_q[gi-1:0];
      end else begin : g_none
        assign taps[gi] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    div_d = clr ? '0 : div_q + 1'b1;
    tick  = taps[sel];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // R2: a divided tick is never followed by another unless the code drops to 0
  a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sel != '0) |=> (!tick || sel == '0));
endmodule

// File: rtl/pc_edge_sync.sv
module pc_edge_sync #(parameter int STAGES = 3) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], pin};
    rise = sh_q[STAGES-2] & ~sh_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/pc_count_latch.sv
module pc_count_latch #(parameter int BUS_W = 8) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               adv,
  input  logic               hi_rd,
  input  logic               lo_rd,
  output logic [2*BUS_W-1:0] cnt,
  output logic [BUS_W-1:0]   held_lo,
  output logic               held
);
  localparam int CNT_W = 2*BUS_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BUS_W-1:0] hold_q, hold_d;
  logic             lat_q, lat_d;

  always_comb begin
    cnt_d  = cnt_q;
    hold_d = hold_q;
    lat_d  = lat_q;
    if (clr) begin
      cnt_d = '0;
      lat_d = 1'b0;
    end else begin
      if (adv) cnt_d = cnt_q + 1'b1;
      if (lo_rd) begin
        lat_d = 1'b0;
      end else if (hi_rd && !lat_q) begin
        lat_d  = 1'b1;
        hold_d = cnt_q[BUS_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
      lat_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      lat_q  <= lat_d;
    end
  end

  assign cnt     = cnt_q;
  assign held_lo = hold_q;
  assign held    = lat_q;

  a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && cnt_q == '1) |=> cnt_q == '0);
  a_r8_restart: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0 && !lat_q));
  a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_rd && !clr && !lo_rd) |=> lat_q);
  a_r6_persist: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && !lo_rd && !clr) |=> lat_q);
  a_r5_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && !clr) |=> $stable(hold_q));
  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    lo_rd |=> !lat_q);
endmodule

// File: rtl/prescaled_count16.sv
module prescaled_count16 import pc_pkg::*; #(parameter int BUS_W = 8) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [BUS_W-1:0] bus_wdata,
  output logic [BUS_W-1:0] bus_rdata,
  input  logic             ext_clk
);
  localparam int CNT_W = 2*BUS_W;

  logic [SEL_W-1:0] sel_q, sel_d;
  logic             ctrl_wr, sw_clr, hi_rd, lo_rd;
  logic             div_tick, ext_rise, adv;
  logic [CNT_W-1:0] cnt;
  logic [BUS_W-1:0] held_lo;
  logic             held;
  logic             unused_wbits;

  assign unused_wbits = ^{bus_wdata[BUS_W-1:CLR_BIT+1], bus_wdata[CLR_BIT-1:SEL_W]};

  always_comb begin
    ctrl_wr = bus_wr && bus_addr == ADDR_CTRL;
    sw_clr  = ctrl_wr && bus_wdata[CLR_BIT];
    hi_rd   = bus_rd && bus_addr == ADDR_HI;
    lo_rd   = bus_rd && bus_addr == ADDR_LO;
    sel_d   = ctrl_wr ? bus_wdata[SEL_W-1:0] : sel_q;
    adv     = (sel_q == SRC_EXT) ? ext_rise : div_tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  pc_prescaler u_div (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (sw_clr),
    .sel  (sel_q),
    .tick (div_tick)
  );

  pc_edge_sync #(.STAGES(3)) u_ext (
    .clk  (clk),
    .rst_n(rst_n),
    .pin  (ext_clk),
    .rise (ext_rise)
  );

  pc_count_latch #(.BUS_W(BUS_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (sw_clr),
    .adv    (adv),
    .hi_rd  (hi_rd),
    .lo_rd  (lo_rd),
    .cnt    (cnt),
    .held_lo(held_lo),
    .held   (held)
  );

  always_comb begin
    unique case (bus_addr)
      ADDR_CTRL: bus_rdata = {{(BUS_W-SEL_W){1'b0}}, sel_q};
      ADDR_HI:   bus_rdata = cnt[CNT_W-1:BUS_W];
      ADDR_LO:   bus_rdata = held ? held_lo : cnt[BUS_W-1:0];
      default:   bus_rdata = '0;
    endcase
  end

  // R7: writes to the count addresses leave the source code alone
  a_r7_ro_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != ADDR_CTRL) |=> $stable(sel_q));
  // R3: with the external source and no synchronized edge, the count holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == SRC_EXT && !ext_rise && !sw_clr) |=> $stable(cnt));
endmodule

// File: tb/prescaled_count16_bench.sv
`timescale 1ns/1ps
module prescaled_count16_bench;
  logic       clk;
  logic       rst_n;
  logic [1:0] addr;
  logic       wr, rd;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       ext;

  int unsigned cyc = 0;
  int base;
  int cur_k;
  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  prescaled_count16 u_prescaled_count16 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
    .bus_wdata(wdata), .bus_rdata(rdata), .ext_clk(ext)
  );

  initial clk = 0;
  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int exp_cnt();
    return ((int'(cyc) - base) >> cur_k) & 16'hFFFF;
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic restart(int k);
    wr_reg(2'd0, 8'h10 | 8'(k));
    base = int'(cyc);
    cur_k = k;
  endtask

  task automatic rd_reg(logic [1:0] a, output int v, output int e);
    @(negedge clk); addr = a; rd = 1;
    #1; v = int'(rdata); e = exp_cnt();
    @(negedge clk); rd = 0;
  endtask

  task automatic read16(string req, output int v, output int e);
    int h, l, e1, e2;
    rd_reg(2'd1, h, e1);
    rd_reg(2'd2, l, e2);
    v = (h << 8) | l; e = e1;
    check(req, v, e1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int v, e, h, l, e1, e2;
    rst_n = 0; wr = 0; rd = 0; addr = 0; wdata = 0; ext = 0; cur_k = 0; base = 0;
    #1;
    addr = 2'd1; #1; check("R1 high in reset", int'(rdata), 0);
    addr = 2'd2; #1; check("R1 low in reset", int'(rdata), 0);
    addr = 2'd0; #1; check("R1 ctrl in reset", int'(rdata), 0);
    repeat (3) @(negedge clk);
    rst_n = 1; base = int'(cyc); cur_k = 0;
    repeat (20) @(negedge clk);
    read16("R1 counts every clock after reset", v, e);
    rd_reg(2'd0, v, e); check("R1 ctrl after reset", v, 0);

    // R2: every divider code at two distances from restart
    for (int k = 0; k < 7; k++) begin
      restart(k);
      repeat (37) @(negedge clk);
      read16($sformatf("R2 code %0d near", k), v, e);
      repeat (200) @(negedge clk);
      read16($sformatf("R2 code %0d far", k), v, e);
      rd_reg(2'd0, v, e); check($sformatf("R8 ctrl readback code %0d", k), v, k);
    end

    // R4: read pair straddling the 0x01FF -> 0x0200 carry
    restart(0);
    repeat (32'h1FE) @(negedge clk);
    rd_reg(2'd1, h, e1);
    check("R4 high at carry", h, 1);
    check("R4 sample point", e1, 32'h1FF);
    rd_reg(2'd2, l, e2);
    check("R4 assembled across carry", (h << 8) | l, 16'h01FF);

    // R5: second high read must not recapture
    restart(0);
    repeat (47) @(negedge clk);
    rd_reg(2'd1, h, e1);
    repeat (20) @(negedge clk);
    rd_reg(2'd1, h, e2);
    check("R5 second high is live", h, (e2 >> 8) & 8'hFF);
    rd_reg(2'd2, l, e);
    check("R5 low keeps first capture", l, e1 & 8'hFF);

    // R6: stale capture, then release
    rd_reg(2'd1, h, e1);
    repeat (1000) @(negedge clk);
    rd_reg(2'd2, l, e);
    check("R6 stale low held", l, e1 & 8'hFF);
    rd_reg(2'd2, l, e);
    check("R6 low live after release", l, e & 8'hFF);

    // R8: restart releases the latch and clears the count
    rd_reg(2'd1, h, e1);
    repeat (5) @(negedge clk);
    restart(0);
    rd_reg(2'd2, l, e);
    check("R8 low live after restart", l, e & 8'hFF);
    check("R8 count restarted", e, 1);

    // R7: writes to count addresses ignored
    wr_reg(2'd1, 8'hAB);
    wr_reg(2'd2, 8'hCD);
    read16("R7 count unaffected by writes", v, e);
    rd_reg(2'd0, v, e); check("R7 ctrl unaffected", v, 0);

    // R9: wrap past 0xFFFF
    restart(0);
    repeat (32'h10004) @(negedge clk);
    read16("R9 wrap", v, e);
    check("R9 wrapped value", e, 5);

    // R3: external edges
    restart(7);
    for (int i = 0; i < 10; i++) begin
      repeat (3) @(negedge clk); ext = 1;
      repeat (3) @(negedge clk); ext = 0;
    end
    repeat (6) @(negedge clk);
    rd_reg(2'd1, h, e); rd_reg(2'd2, l, e);
    check("R3 ten external edges", (h << 8) | l, 10);
    repeat (40) @(negedge clk);
    rd_reg(2'd1, h, e); rd_reg(2'd2, l, e);
    check("R3 static pin holds", (h << 8) | l, 10);
    rd_reg(2'd0, v, e); check("R8 ctrl readback code 7", v, 7);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule